// File: doc/BRIEF.md
# Temperature Conversion Sequencer with Configuration Register

This block sits between a serial-bus front end and a modelled temperature converter. It keeps the single configuration byte that software reads and writes, and it sequences one conversion per start request. The conversion lasts a number of prescaled ticks that depends on the selected resolution. At the end it captures the converter's 14-bit code and presents a left-justified 16-bit result word.

A software reset puts the configuration back to its default and cancels any conversion in progress. The block then stays not-ready for a recovery period. A supply-low status input shows up live in the configuration byte. All durations are parameters counted in ticks of a clock prescaler, so a simulation can use short delays and silicon can use real ones.

Top module: `tconv_ctrl`

## Requirements
- R1: After reset, `cfg_rd_data` reads 0x3A (with `supply_low` = 0), `busy` and `done` are 0, `ready` is 1 and `result` is 0.
- R2: The resolution code is {bit 7, bit 0} of the configuration byte: 00 selects 14 bits, 01 selects 12 bits, 10 selects 13 bits and 11 selects 11 bits. A write with `cfg_wr_en` updates only these two bits, and the new value is visible on `cfg_rd_data` from the next cycle.
- R3: Bit 6 of `cfg_rd_data` always equals `supply_low`. Bits 5..1 always read 5'b11101. Writes have no effect on bits 6..1.
- R4: A `start` accepted while idle and ready raises `busy` in the next cycle. `busy` then stays high for exactly TICKS_x × PRESCALE cycles, where TICKS_x is chosen by the resolution code in effect when the start was accepted. A later configuration write does not change a running conversion.
- R5: `done` is high for exactly one cycle, starting at the same clock edge at which `busy` falls. `result` is captured from `adc_code` at that edge.
- R6: `result[15:2]` equals `adc_code` with its low (14 − resolution) bits cleared, and `result[1:0]` is 00. `result` holds its value until the next completed conversion.
- R7: A `start` that arrives while `busy` is high, or during reset recovery, is ignored. A running conversion keeps its original duration, and after recovery no conversion begins.
- R8: `sw_reset` clears the resolution bits so the byte reads 0x3A again, aborts a running conversion without pulsing `done`, and leaves `result` unchanged. `ready` is 0 for exactly TICKS_RECOV × PRESCALE cycles after the reset edge and then returns to 1.
- R9: If `sw_reset` arrives in the same cycle as `start` or a configuration write, `sw_reset` wins: no conversion begins and the write is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_data | input | 8 | Configuration write byte |
| cfg_rd_data | output | 8 | Configuration byte as read |
| supply_low | input | 1 | Supply-low status from the supply monitor |
| sw_reset | input | 1 | Software reset request (one-cycle pulse) |
| start | input | 1 | Conversion start request (one-cycle pulse) |
| adc_code | input | 14 | Full-width code from the modelled converter |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle pulse when a result is latched |
| ready | output | 1 | Low during software-reset recovery |
| result | output | 16 | Left-justified, zero-padded result word |

## Verification
Conversions are run at each of the four resolution codes with random converter codes. This separates the non-monotonic mapping of the code to both the duration and the zero mask: if two codes were swapped, both the busy length and the cleared low bits would be wrong. Extra start pulses and configuration writes are injected partway through a conversion to show that neither restarts the timer nor changes the latched resolution. Software reset is applied when idle, partway through a conversion, and together with a start and a write. Together these cover the abort, recovery length and priority cases.

// File: rtl/tconv_pkg.sv
package tconv_pkg;
  localparam int ADC_W = 14;
  localparam int RES_W = 16;
  localparam logic [4:0] RSVD_PAT = 5'b11101;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CONV  = 2'd1,
    ST_RECOV = 2'd2
  } seq_state_e;

  // Effective resolution for the two-bit code {bit7, bit0}
  function automatic int unsigned res_bits(input logic [1:0] code);
    case (code)
      2'b00:   res_bits = 14;
      2'b01:   res_bits = 12;
      2'b10:   res_bits = 13;
      default: res_bits = 11;
    endcase
  endfunction

  // Keep the top res_bits of the code, clear the rest, append two zero bits
  function automatic logic [RES_W-1:0] format_result(input logic [1:0] code,
                                                     input logic [ADC_W-1:0] raw);
    logic [ADC_W-1:0] mask;
    mask = {ADC_W{1'b1}} << (ADC_W - res_bits(code));
    format_result = {raw & mask, 2'b00};
  endfunction
endpackage

// File: rtl/tconv_tick.sv
module tconv_tick #(
  parameter int PRESCALE = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  output logic tick
);
  localparam int PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;
  localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);

  logic [PW-1:0] cnt_q, cnt_d;

  assign tick = run && !clr && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (run)  cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R4: ticks only occur while a timed phase runs
  p_tick_needs_run_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);
endmodule

// File: rtl/tconv_cfg_reg.sv
module tconv_cfg_reg
  import tconv_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       sw_reset,
  input  logic       supply_low,
  output logic [1:0] res_code,
  output logic [7:0] rd_data
);
  logic [1:0] res_q, res_d;

  always_comb begin
    res_d = res_q;
    if (sw_reset)   res_d = 2'b00;
    else if (wr_en) res_d = {wr_data[7], wr_data[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) res_q <= 2'b00;
    else        res_q <= res_d;
  end

  assign res_code = res_q;
  assign rd_data  = {res_q[1], supply_low, RSVD_PAT, res_q[0]};

  // R8/R9: software reset restores the default resolution whatever else happens
  p_swreset_default_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (rd_data[7] == 1'b0) && (rd_data[0] == 1'b0));
  // R2: a write lands in the split resolution field
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sw_reset) |=> (res_code == $past({wr_data[7], wr_data[0]})));
endmodule

// File: rtl/tconv_seq.sv
module tconv_seq
  import tconv_pkg::*;
#(
  parameter int TICKS_14    = 70,
  parameter int TICKS_13    = 40,
  parameter int TICKS_12    = 24,
  parameter int TICKS_11    = 15,
  parameter int TICKS_RECOV = 50
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             sw_reset,
  input  logic             tick,
  input  logic [1:0]       res_code,
  input  logic [ADC_W-1:0] adc_code,
  output logic             pre_run,
  output logic             pre_clr,
  output logic             busy,
  output logic             done,
  output logic             ready,
  output logic [RES_W-1:0] result
);
  localparam int MAX_A  = (TICKS_14 > TICKS_13) ? TICKS_14 : TICKS_13;
  localparam int MAX_B  = (TICKS_12 > TICKS_11) ? TICKS_12 : TICKS_11;
  localparam int MAX_C  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int MAX_T  = (MAX_C > TICKS_RECOV) ? MAX_C : TICKS_RECOV;
  localparam int CW     = $clog2(MAX_T + 1);

  seq_state_e       state_q, state_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic [1:0]       code_q, code_d;
  logic             done_q, done_d;
  logic [RES_W-1:0] result_q, result_d;
  logic [CW-1:0]    conv_last;

  always_comb begin
    case (code_q)
      2'b00:   conv_last = CW'(TICKS_14 - 1);
      2'b01:   conv_last = CW'(TICKS_12 - 1);
      2'b10:   conv_last = CW'(TICKS_13 - 1);
      default: conv_last = CW'(TICKS_11 - 1);
    endcase
  end

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    code_d   = code_q;
    done_d   = 1'b0;
    result_d = result_q;
    pre_clr  = 1'b0;
    if (sw_reset) begin
      state_d = ST_RECOV;
      cnt_d   = '0;
      pre_clr = 1'b1;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_d = ST_CONV;
          cnt_d   = '0;
          code_d  = res_code;
          pre_clr = 1'b1;
        end
        ST_CONV: if (tick) begin
          if (cnt_q == conv_last) begin
            state_d  = ST_IDLE;
            done_d   = 1'b1;
            result_d = format_result(code_q, adc_code);
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_RECOV: if (tick) begin
          if (cnt_q == CW'(TICKS_RECOV - 1)) state_d = ST_IDLE;
          else                               cnt_d   = cnt_q + 1'b1;
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      code_q   <= 2'b00;
      done_q   <= 1'b0;
      result_q <= '0;
    end else begin
      state_q  <= state_d;
      cnt_q    <= cnt_d;
      code_q   <= code_d;
      done_q   <= done_d;
      result_q <= result_d;
    end
  end

  assign pre_run = (state_q != ST_IDLE);
  assign busy    = (state_q == ST_CONV);
  assign ready   = (state_q != ST_RECOV);
  assign done    = done_q;
  assign result  = result_q;

  // R5: done is a single-cycle pulse marking the end of busy
  p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  // R6: latched word always carries two zero padding bits
  p_result_pad_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (result[1:0] == 2'b00));
  // R7: a start during a conversion does not restart the tick count
  p_ignore_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !sw_reset && !tick) |=> (busy && $stable(cnt_q)));
  // R8: software reset aborts quietly and enters recovery
  p_abort_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sw_reset |=> (!done && !busy && !ready && $stable(result)));
endmodule

// File: rtl/tconv_ctrl.sv
module tconv_ctrl
  import tconv_pkg::*;
#(
  parameter int PRESCALE    = 4,
  parameter int TICKS_14    = 70,
  parameter int TICKS_13    = 40,
  parameter int TICKS_12    = 24,
  parameter int TICKS_11    = 15,
  parameter int TICKS_RECOV = 50
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr_en,
  input  logic [7:0]  cfg_wr_data,
  output logic [7:0]  cfg_rd_data,
  input  logic        supply_low,
  input  logic        sw_reset,
  input  logic        start,
  input  logic [13:0] adc_code,
  output logic        busy,
  output logic        done,
  output logic        ready,
  output logic [15:0] result
);
  logic [1:0] res_code;
  logic       tick, pre_run, pre_clr;

  tconv_cfg_reg u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (cfg_wr_en),
    .wr_data    (cfg_wr_data),
    .sw_reset   (sw_reset),
    .supply_low (supply_low),
    .res_code   (res_code),
    .rd_data    (cfg_rd_data)
  );

  tconv_tick #(.PRESCALE(PRESCALE)) u_tick (
    .clk   (clk),
    .rst_n (rst_n),
    .run   (pre_run),
    .clr   (pre_clr),
    .tick  (tick)
  );

  tconv_seq #(
    .TICKS_14    (TICKS_14),
    .TICKS_13    (TICKS_13),
    .TICKS_12    (TICKS_12),
    .TICKS_11    (TICKS_11),
    .TICKS_RECOV (TICKS_RECOV)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .sw_reset (sw_reset),
    .tick     (tick),
    .res_code (res_code),
    .adc_code (adc_code),
    .pre_run  (pre_run),
    .pre_clr  (pre_clr),
    .busy     (busy),
    .done     (done),
    .ready    (ready),
    .result   (result)
  );
endmodule

// File: tb/test_tconv_ctrl.sv
module test_tconv_ctrl;
  localparam int P   = 4;
  localparam int T14 = 70;
  localparam int T13 = 40;
  localparam int T12 = 24;
  localparam int T11 = 15;
  localparam int TR  = 50;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr_en;
  logic [7:0]  cfg_wr_data;
  logic [7:0]  cfg_rd_data;
  logic        supply_low;
  logic        sw_reset;
  logic        start;
  logic [13:0] adc_code;
  logic        busy, done, ready;
  logic [15:0] result;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  tconv_ctrl #(.PRESCALE(P), .TICKS_14(T14), .TICKS_13(T13), .TICKS_12(T12),
               .TICKS_11(T11), .TICKS_RECOV(TR)) i_tconv_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .supply_low(supply_low), .sw_reset(sw_reset),
    .start(start), .adc_code(adc_code), .busy(busy), .done(done),
    .ready(ready), .result(result));

  function automatic int exp_cycles(input logic [1:0] c);
    case (c)
      2'b00:   return T14 * P;
      2'b01:   return T12 * P;
      2'b10:   return T13 * P;
      default: return T11 * P;
    endcase
  endfunction

  function automatic logic [15:0] exp_result(input logic [1:0] c, input logic [13:0] a);
    int bits;
    logic [13:0] m;
    case (c)
      2'b00: bits = 14; 2'b01: bits = 12; 2'b10: bits = 13; default: bits = 11;
    endcase
    m = 14'h3FFF << (14 - bits);
    return {a & m, 2'b00};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr_cfg(input logic [7:0] b);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wr_data = b;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  // Run one conversion; optionally inject a start and a config write mid-way
  task automatic convert(input logic [1:0] c, input logic [13:0] a, input bit disturb);
    int cnt;
    logic [1:0] other;
    other = ~c;
    wr_cfg({c[1], 6'b000000, c[0]});
    chk("R2 code readback", {cfg_rd_data[7], cfg_rd_data[0]}, c);
    @(negedge clk); start = 1'b1; adc_code = a;
    @(negedge clk); start = 1'b0;
    chk("R4 busy rises", busy, 1'b1);
    cnt = 0;
    while (busy && cnt < 10000) begin
      cnt++;
      if (disturb) begin
        start = (cnt == 3);                        // R7: ignored start
        cfg_wr_en = (cnt == 5);                    // R4: resolution latched
        cfg_wr_data = {other[1], 6'b0, other[0]};
      end
      @(negedge clk);
    end
    start = 1'b0; cfg_wr_en = 1'b0;
    chk(disturb ? "R7 busy length with mid start" : "R4 busy length", cnt, exp_cycles(c));
    chk("R5 done at busy fall", done, 1'b1);
    chk("R6 result format", result, exp_result(c, a));
    @(negedge clk);
    chk("R5 done one cycle", done, 1'b0);
    chk("R6 result held", result, exp_result(c, a));
  endtask

  task automatic wait_recovery(input bit poke_start);
    int cnt;
    cnt = 0;
    while (!ready && cnt < 10000) begin
      cnt++;
      start = poke_start && (cnt == 2);            // R7: ignored during recovery
      @(negedge clk);
    end
    start = 1'b0;
    chk("R8 recovery length", cnt, TR * P);
    @(negedge clk);
    chk("R7 no conversion after recovery", busy, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] held;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; cfg_wr_en = 1'b0; cfg_wr_data = 8'h00; supply_low = 1'b0;
    sw_reset = 1'b0; start = 1'b0; adc_code = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    chk("R1 cfg reset", cfg_rd_data, 8'h3A);
    chk("R1 busy reset", busy, 1'b0);
    chk("R1 done reset", done, 1'b0);
    chk("R1 ready reset", ready, 1'b1);
    chk("R1 result reset", result, 16'h0000);

    // R3: writes cannot touch bits 6..1; bit 6 follows supply_low
    wr_cfg(8'h00);  chk("R3 write 00", cfg_rd_data, 8'h3A);
    wr_cfg(8'hFF);  chk("R3 write FF", cfg_rd_data, 8'hBB);
    supply_low = 1'b1; @(negedge clk);
    chk("R3 supply low", cfg_rd_data, 8'hFB);
    supply_low = 1'b0; @(negedge clk);
    chk("R3 supply ok", cfg_rd_data, 8'hBB);
    wr_cfg(8'h7E);  chk("R2 write 7E", cfg_rd_data, 8'h3A);

    // R4/R6 directed: every code with an all-ones converter code
    for (int c = 0; c < 4; c++) convert(2'(c), 14'h3FFF, 1'b0);
    // R4/R7 disturbed runs
    convert(2'b11, 14'h2AAB, 1'b1);
    convert(2'b00, 14'h1555, 1'b1);
    // random mix
    for (int i = 0; i < 8; i++) convert(2'($urandom % 4), 14'($urandom), 1'b0);

    // R8: software reset while idle from a non-default resolution
    wr_cfg(8'h81);
    @(negedge clk); sw_reset = 1'b1;
    @(negedge clk); sw_reset = 1'b0;
    chk("R8 cfg default", cfg_rd_data, 8'h3A);
    chk("R8 ready low", ready, 1'b0);
    wait_recovery(1'b1);

    // R8: abort mid-conversion
    held = result;
    @(negedge clk); start = 1'b1; adc_code = 14'h0F0F;
    @(negedge clk); start = 1'b0;
    repeat (10) @(negedge clk);
    sw_reset = 1'b1;
    @(negedge clk); sw_reset = 1'b0;
    chk("R8 abort busy", busy, 1'b0);
    chk("R8 abort done", done, 1'b0);
    begin
      int seen_done;
      seen_done = 0;
      for (int k = 0; k < TR * P + 4; k++) begin
        if (done) seen_done++;
        @(negedge clk);
      end
      chk("R8 no done after abort", seen_done, 0);
    end
    chk("R8 result unchanged", result, held);
    chk("R8 ready restored", ready, 1'b1);

    // R9: reset with start and write in the same cycle
    @(negedge clk); sw_reset = 1'b1; start = 1'b1; cfg_wr_en = 1'b1; cfg_wr_data = 8'h81;
    @(negedge clk); sw_reset = 1'b0; start = 1'b0; cfg_wr_en = 1'b0;
    chk("R9 no start", busy, 1'b0);
    chk("R9 write dropped", cfg_rd_data, 8'h3A);
    chk("R9 recovering", ready, 1'b0);
    wait_recovery(1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule